// File: doc/BRIEF.md
# Bus Cycle Classifier for a Cache Controller

This block sits beside the local bus of a 32-bit processor, inside a cache controller. It sorts every new bus cycle into one of four classes: coprocessor access, local-bus access, non-cacheable access, or cacheable memory access.

A new cycle is seen when the address strobe is low at a clock edge. At that same edge the block samples the address, the memory/I-O select, the byte enables and three configuration inputs: local-bus, no-cache and 16-bit. It holds the resulting class until the ready strobe ends the cycle. For coprocessor and local-bus cycles it reports the controller as idle, so that the cache takes no action. For 16-bit transfers whose byte enables touch both halves of the data word, it raises a lock request. The lock keeps the two halves of the split transfer together.

The rest of the controller reads the class vector to choose how to handle the cycle. It reads the idle flag to decide whether to stay out of the cycle.

Top module: `cycle_classifier`

## Requirements
- R1: An I/O cycle (`memIoN`=0) whose address MSB is 1 is classed as coprocessor, one-hot bit 3 of `cycleClass`. This holds whatever the configuration inputs are, and it covers addresses 800000F8h and 800000FCh.
- R2: Any other cycle with `localBusN`=0 is classed as local-bus, bit 2.
- R3: Any other cycle with `bus16N`=0 is a 16-bit transfer and is classed as non-cacheable, bit 1.
- R4: Any other cycle with `noCacheN`=0 is classed as non-cacheable, bit 1. A non-coprocessor I/O cycle is also classed as non-cacheable, bit 1.
- R5: All remaining cycles are memory cycles and are classed as cacheable, bit 0.
- R6: The class appears in the cycle after the edge where `adsN` is low, with exactly one bit set. It stays unchanged until an edge where `readyN` is low, and it is all zero after that edge.
- R7: `idle` is 1 when no cycle is open, and during coprocessor or local-bus cycles. It is 0 during cacheable and non-cacheable cycles. With no coprocessor fitted, a coprocessor cycle keeps `idle` high until `readyN` arrives.
- R8: `lockReq` is 1 during a cycle classed by R3 when at least one of `beN[1:0]` and at least one of `beN[3:2]` are low (the enables are active low). It is 0 if only one half is enabled, or if a higher-priority class won. It clears when the cycle ends.
- R9: Changes to the address and configuration inputs after the strobe edge have no effect on an open cycle.
- R10: While `rst` is high at a clock edge, the class and the lock are cleared after that edge.
- R11: If `adsN` and `readyN` are both low at one edge, the old cycle ends and the new cycle's class is latched at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Processor address |
| memIoN | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| adsN | input | 1 | Address strobe, active low |
| readyN | input | 1 | Cycle end strobe, active low |
| beN | input | BE_W | Byte enables, active low |
| localBusN | input | 1 | Cycle belongs to a local-bus device, active low |
| noCacheN | input | 1 | Access is non-cacheable, active low |
| bus16N | input | 1 | 16-bit transfer, active low |
| cycleClass | output | 4 | One-hot class: 0 cacheable, 1 non-cacheable, 2 local, 3 coprocessor |
| idle | output | 1 | Controller must stay out of the cycle |
| lockReq | output | 1 | Lock request for a split 16-bit transfer |

## Verification
Class and lock are registered, so each one is due exactly one clock after the edge that sampled the strobe. The clear is due one clock after the edge that sampled `readyN`. `idle` follows the class with no further delay. The bench changes inputs on falling edges and compares all outputs on the next falling edge, which lies half a period after the edge that updated them. While a cycle is open, the bench scrambles the configuration inputs and checks on every wait cycle that nothing has moved.

// File: rtl/cyc_cls_pkg.sv
package cyc_cls_pkg;
  localparam int CLS_N = 4;
  localparam int CLS_CACHE   = 0;
  localparam int CLS_NOCACHE = 1;
  localparam int CLS_LOCAL   = 2;
  localparam int CLS_COPRO   = 3;

  typedef struct packed {
    logic load;   // latch a new cycle at this edge
    logic clear;  // current cycle ends at this edge
  } ctlStrobe_t;
endpackage

// File: rtl/cyc_cls_ctrl.sv
module cyc_cls_ctrl
  import cyc_cls_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adsN,
  input  logic       readyN,
  output ctlStrobe_t strobe
);
  logic busy;

  always_comb begin
    strobe.load  = !adsN;
    strobe.clear = busy && !readyN && adsN;
  end

  always_ff @(posedge clk) begin
    if (rst)               busy <= 1'b0;
    else if (strobe.load)  busy <= 1'b1;
    else if (strobe.clear) busy <= 1'b0;
  end
endmodule

// File: rtl/cyc_cls_dp.sv
module cyc_cls_dp
  import cyc_cls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memIoN,
  input  logic [BE_W-1:0]   beN,
  input  logic              localBusN,
  input  logic              noCacheN,
  input  logic              bus16N,
  output logic [CLS_N-1:0]  cycleClass,
  output logic              lockReq
);
  localparam int HALF = BE_W / 2;

  logic isCopro, lowUsed, highUsed, spans;
  logic [CLS_N-1:0] nextClass;
  logic nextLock;

  assign isCopro  = !memIoN && addr[ADDR_W-1];
  assign lowUsed  = !(&beN[HALF-1:0]);
  assign highUsed = !(&beN[BE_W-1:HALF]);
  assign spans    = lowUsed && highUsed;

  always_comb begin
    nextClass = '0;
    nextLock  = 1'b0;
    if (isCopro)        nextClass[CLS_COPRO] = 1'b1;
    else if (!localBusN) nextClass[CLS_LOCAL] = 1'b1;
    else if (!bus16N) begin
      nextClass[CLS_NOCACHE] = 1'b1;
      nextLock = spans;
    end
    else if (!noCacheN || !memIoN) nextClass[CLS_NOCACHE] = 1'b1;
    else                 nextClass[CLS_CACHE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || (strobe.clear && !strobe.load)) begin
      cycleClass <= '0;
      lockReq    <= 1'b0;
    end else if (strobe.load) begin
      cycleClass <= nextClass;
      lockReq    <= nextLock;
    end
  end
endmodule

// File: rtl/cycle_classifier.sv
module cycle_classifier
  import cyc_cls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memIoN,
  input  logic              adsN,
  input  logic              readyN,
  input  logic [BE_W-1:0]   beN,
  input  logic              localBusN,
  input  logic              noCacheN,
  input  logic              bus16N,
  output logic [3:0]        cycleClass,
  output logic              idle,
  output logic              lockReq
);
  ctlStrobe_t strobe;

  cyc_cls_ctrl u_ctrl (
    .clk(clk), .rst(rst), .adsN(adsN), .readyN(readyN), .strobe(strobe)
  );

  cyc_cls_dp #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .addr(addr), .memIoN(memIoN),
    .beN(beN), .localBusN(localBusN), .noCacheN(noCacheN), .bus16N(bus16N),
    .cycleClass(cycleClass), .lockReq(lockReq)
  );

  assign idle = (cycleClass == '0) || cycleClass[CLS_COPRO] || cycleClass[CLS_LOCAL];
endmodule

// File: rtl/cyc_cls_chk.sv
module cyc_cls_chk #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              memIoN,
  input logic              adsN,
  input logic              readyN,
  input logic              localBusN,
  input logic [3:0]        cycleClass,
  input logic              idle,
  input logic              lockReq
);
  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cycleClass)); // R6

  AST_COPRO_WINS: assert property (@(posedge clk) disable iff (rst)
    (!adsN && !memIoN && addr[ADDR_W-1]) |=> (cycleClass == 4'b1000)); // R1

  AST_LOCAL_CLASS: assert property (@(posedge clk) disable iff (rst)
    (!adsN && !localBusN && !(!memIoN && addr[ADDR_W-1])) |=> (cycleClass == 4'b0100)); // R2

  AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (rst)
    (cycleClass != 4'b0 && readyN && adsN) |=> ($stable(cycleClass) && $stable(lockReq))); // R9

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cycleClass != 4'b0 && !readyN && adsN) |=> (cycleClass == 4'b0 && !lockReq)); // R6

  AST_LOCK_NOCACHE: assert property (@(posedge clk) disable iff (rst)
    lockReq |-> cycleClass[1]); // R8

  AST_BUSY_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cycleClass[0] || cycleClass[1]) |-> !idle); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cycleClass == 4'b0 && !lockReq)); // R10
endmodule

bind cycle_classifier cyc_cls_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .memIoN(memIoN), .adsN(adsN),
  .readyN(readyN), .localBusN(localBusN), .cycleClass(cycleClass),
  .idle(idle), .lockReq(lockReq)
);

// File: tb/cycle_classifier_test.sv
module cycle_classifier_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] addr = '0;
  logic memIoN = 1'b1, adsN = 1'b1, readyN = 1'b1;
  logic [3:0] beN = 4'hF;
  logic localBusN = 1'b1, noCacheN = 1'b1, bus16N = 1'b1;
  logic [3:0] cycleClass;
  logic idle, lockReq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cycle_classifier uut (
    .clk(clk), .rst(rst), .addr(addr), .memIoN(memIoN), .adsN(adsN),
    .readyN(readyN), .beN(beN), .localBusN(localBusN), .noCacheN(noCacheN),
    .bus16N(bus16N), .cycleClass(cycleClass), .idle(idle), .lockReq(lockReq)
  );

  function automatic logic [3:0] expClass(logic mio, logic a31, logic lb, logic x16, logic nc);
    if (!mio && a31) return 4'b1000;
    if (!lb)         return 4'b0100;
    if (!x16)        return 4'b0010;
    if (!nc || !mio) return 4'b0010;
    return 4'b0001;
  endfunction

  function automatic logic expLock(logic [3:0] cls, logic x16, logic [3:0] be);
    return (cls == 4'b0010) && !x16 && (be[1:0] != 2'b11) && (be[3:2] != 2'b11);
  endfunction

  function automatic logic expIdle(logic [3:0] cls);
    return (cls == 4'b0) || cls[3] || cls[2];
  endfunction

  function automatic string clsReq(logic [3:0] cls, logic mio, logic x16);
    if (cls[3]) return "R1";
    if (cls[2]) return "R2";
    if (cls[1]) return (!x16) ? "R3" : "R4";
    return "R5";
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkIdleState(string req);
    check(req, {4'b0, cycleClass}, 8'h0);
    check(req, {7'b0, lockReq}, 8'h0);
    check("R7", {7'b0, idle}, 8'h1);
  endtask

  task automatic doCycle(logic mio, logic [31:0] a, logic lb, logic x16, logic nc,
                         logic [3:0] be, int waits);
    logic [3:0] ec;
    logic el;
    ec = expClass(mio, a[31], lb, x16, nc);
    el = expLock(ec, x16, be);
    @(negedge clk);
    adsN = 0; readyN = 1; memIoN = mio; addr = a;
    localBusN = lb; bus16N = x16; noCacheN = nc; beN = be;
    @(negedge clk);
    adsN = 1;
    check(clsReq(ec, mio, x16), {4'b0, cycleClass}, {4'b0, ec});
    check("R8", {7'b0, lockReq}, {7'b0, el});
    check("R7", {7'b0, idle}, {7'b0, expIdle(ec)});
    for (int i = 0; i < waits; i++) begin
      addr = $urandom; memIoN = $urandom; localBusN = $urandom;
      bus16N = $urandom; noCacheN = $urandom; beN = $urandom;
      @(negedge clk);
      check("R9", {4'b0, cycleClass}, {4'b0, ec});
      check("R9", {7'b0, lockReq}, {7'b0, el});
    end
    readyN = 0;
    @(negedge clk);
    readyN = 1;
    checkIdleState("R6");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checkIdleState("R10");
    rst = 0;
    // directed corners
    doCycle(0, 32'h800000F8, 0, 0, 0, 4'b0000, 2);   // R1 beats every config input
    doCycle(0, 32'h800000FC, 1, 1, 1, 4'b0000, 12);  // R7 coprocessor absent: long idle wait
    doCycle(1, 32'h00001000, 0, 0, 1, 4'b0000, 1);   // R2 over R3, R8 no lock
    doCycle(1, 32'h00002000, 1, 0, 1, 4'b1010, 1);   // R8 both halves
    doCycle(1, 32'h00002000, 1, 0, 1, 4'b1100, 1);   // R8 lower half only
    doCycle(1, 32'h00002000, 1, 0, 1, 4'b0011, 0);   // R8 upper half only
    doCycle(0, 32'h000003F8, 1, 1, 1, 4'b1110, 0);   // R4 plain I/O
    doCycle(1, 32'h80000000, 1, 1, 0, 4'b0000, 1);   // R4 memory with MSB set
    doCycle(1, 32'h00004000, 1, 1, 1, 4'b0000, 0);   // R5
    // R11 back-to-back: strobe and ready at one edge
    @(negedge clk);
    adsN = 0; memIoN = 1; addr = 32'h10; localBusN = 1; bus16N = 1; noCacheN = 1; beN = 0;
    @(negedge clk);
    check("R11", {4'b0, cycleClass}, 8'h01);
    readyN = 0; memIoN = 0; addr = 32'h800000F8;
    @(negedge clk);
    adsN = 1; readyN = 1;
    check("R11", {4'b0, cycleClass}, 8'h08);
    readyN = 0;
    @(negedge clk);
    readyN = 1;
    checkIdleState("R6");
    // R10 reset in the middle of a locked cycle
    @(negedge clk);
    adsN = 0; memIoN = 1; addr = 32'h20; bus16N = 0; beN = 4'b0000;
    @(negedge clk);
    adsN = 1;
    check("R8", {7'b0, lockReq}, 8'h1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    checkIdleState("R10");
    bus16N = 1;
    // random traffic
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom_range(3) == 0) a = 32'h800000F8 | (($urandom_range(1)) << 2);
      doCycle($urandom, a, ($urandom_range(3) != 0), ($urandom_range(2) != 0),
              ($urandom_range(2) != 0), $urandom, $urandom_range(4));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule